// File: doc/BRIEF.md
# Per-Line Interrupt Request Arbiter

This block holds the interrupt requests of a multi-line serial terminal interface. Each line owns one receive request bit and one transmit request bit. The bits sit in two 16-bit pending vectors, one per group. Each group drives a master request output that stays high while any of its bits is pending. The register logic and the data logic around the block raise and drop bits through per-line set and clear inputs. The block also applies two rules on its own: the interrupt-enable rule for control-register writes, and the transmit-completion rule.

When the processor acknowledges a group, the block picks the lowest-numbered pending line of that group and clears its bit. It then returns an interrupt vector built from a programmable base. A receive vector sits on an 8-aligned slot per line. A transmit vector sits 4 above the receive slot of the same line. The vector is registered and holds until the next acknowledge of that group.

Top module: `irq_line_arbiter`

## Requirements
- R1: `rx_irq` / `tx_irq` is high exactly when the group's pending vector (`rx_pend` / `tx_pend`, bit i = line i) is non-zero. Both change together on the clock edge after the cause.
- R2: Each clock cycle in which `rx_ack` (or `tx_ack`) is high is one acknowledge. It clears the lowest-numbered pending bit of that group at the same edge.
- R3: After an acknowledge of line k, the vector output holds its new value from the next cycle until the next acknowledge of that group. `rx_vec` = `vec_base` + 8·k and `tx_vec` = `vec_base` + 8·k + 4.
- R4: An acknowledge of a group with no pending bit sets that group's vector to 0 and changes no pending bit.
- R5: A control write (`csr_wr_en`) with `csr_wr_ie`=0 clears the pending bit of line `csr_wr_line`. It acts on the group chosen by `csr_wr_grp`: 0 = receive, 1 = transmit.
- R6: A control write with `csr_wr_ie`=1, `csr_wr_done`=1 and `csr_wr_ie_old`=0 sets the selected pending bit. A write with `csr_wr_ie`=1 and either `csr_wr_ie_old`=1 or `csr_wr_done`=0 leaves the pending bits unchanged.
- R7: A transmit completion pulse on `tx_cmpl[i]` sets transmit pending bit i when `tx_ie[i]` is 1. It has no effect when `tx_ie[i]` is 0.
- R8: `line_reset[i]` clears both the receive and the transmit pending bit of line i.
- R9: Within one cycle, any set source for a bit wins over every clear source for that bit. The clear sources are the direct clear, the line reset, a control write and the acknowledge.
- R10: The direct inputs `rx_set`/`tx_set` and `rx_clr`/`tx_clr` set and clear the pending bits of the lines whose bits are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vec_base | input | 9 | Programmable vector base |
| line_reset | input | 16 | Per-line reset of both request bits |
| rx_set | input | 16 | Direct receive request set, one bit per line |
| rx_clr | input | 16 | Direct receive request clear, one bit per line |
| tx_set | input | 16 | Direct transmit request set, one bit per line |
| tx_clr | input | 16 | Direct transmit request clear, one bit per line |
| tx_cmpl | input | 16 | Transmit completion pulse per line |
| tx_ie | input | 16 | Transmit interrupt enable per line |
| csr_wr_en | input | 1 | Control-register write event |
| csr_wr_grp | input | 1 | Group of the write: 0 receive, 1 transmit |
| csr_wr_line | input | 4 | Line of the write |
| csr_wr_ie | input | 1 | Interrupt enable value being written |
| csr_wr_ie_old | input | 1 | Interrupt enable value before the write |
| csr_wr_done | input | 1 | Done flag of the register at the write |
| rx_ack | input | 1 | Receive group acknowledge |
| tx_ack | input | 1 | Transmit group acknowledge |
| rx_irq | output | 1 | Receive master request |
| tx_irq | output | 1 | Transmit master request |
| rx_pend | output | 16 | Receive pending vector |
| tx_pend | output | 16 | Transmit pending vector |
| rx_vec | output | 9 | Vector of the last receive acknowledge |
| tx_vec | output | 9 | Vector of the last transmit acknowledge |

## Verification
The hardest situation to reach is an acknowledge that lands on a bit in the same cycle as a set of that same bit. In that cycle the vector must report the line while the bit survives. The stimulus first makes a line the lowest pending one. It then raises the acknowledge and a direct set of that line on the same falling edge, together with a direct clear and a line reset of it. Acknowledges held for two back-to-back cycles are also driven, to show that each cycle services a different line.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
    typedef enum logic {
        GRP_RX = 1'b0,
        GRP_TX = 1'b1
    } grp_e;

    localparam int NUM_GROUPS = 2;
endpackage

// File: rtl/irq_pick_lowest.sv
module irq_pick_lowest #(
    parameter int NUM_LINES = 16,
    localparam int LW = $clog2(NUM_LINES)
) (
    input  logic [NUM_LINES-1:0] req,
    output logic                 found,
    output logic [LW-1:0]        idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = LW'(i);
            end
        end
    end
endmodule

// File: rtl/irq_pend_group.sv
module irq_pend_group #(
    parameter int NUM_LINES   = 16,
    parameter int VEC_W       = 9,
    parameter int LINE_STRIDE = 8,
    parameter int GRP_OFFSET  = 0,
    localparam int LW = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [VEC_W-1:0]     vec_base,
    input  logic [NUM_LINES-1:0] set_in,
    input  logic [NUM_LINES-1:0] clr_in,
    input  logic                 ack,
    output logic [NUM_LINES-1:0] pend,
    output logic                 irq,
    output logic [VEC_W-1:0]     vec
);
    typedef struct packed {
        logic [NUM_LINES-1:0] pend;
        logic                 irq;
        logic [VEC_W-1:0]     vec;
    } grp_state_t;

    grp_state_t st_d, st_q;
    logic            win_found;
    logic [LW-1:0]   win_idx;
    logic [NUM_LINES-1:0] ack_clr;

    irq_pick_lowest #(.NUM_LINES(NUM_LINES)) u_pick (
        .req   (st_q.pend),
        .found (win_found),
        .idx   (win_idx)
    );

    always_comb begin
        st_d    = st_q;
        ack_clr = '0;
        if (ack) begin
            if (win_found) begin
                ack_clr[win_idx] = 1'b1;
                st_d.vec = vec_base
                         + VEC_W'(VEC_W'(win_idx) * VEC_W'(LINE_STRIDE))
                         + VEC_W'(GRP_OFFSET);
            end else begin
                st_d.vec = '0;
            end
        end
        // set sources win over every clear source
        st_d.pend = (st_q.pend & ~clr_in & ~ack_clr) | set_in;
        st_d.irq  = |st_d.pend;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend = st_q.pend;
    assign irq  = st_q.irq;
    assign vec  = st_q.vec;
endmodule

// File: rtl/irq_line_arbiter.sv
module irq_line_arbiter
    import irq_arb_pkg::*;
#(
    parameter int NUM_LINES   = 16,
    parameter int VEC_W       = 9,
    parameter int LINE_STRIDE = 8,
    parameter int TX_OFFSET   = 4,
    localparam int LW = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [VEC_W-1:0]     vec_base,
    input  logic [NUM_LINES-1:0] line_reset,
    input  logic [NUM_LINES-1:0] rx_set,
    input  logic [NUM_LINES-1:0] rx_clr,
    input  logic [NUM_LINES-1:0] tx_set,
    input  logic [NUM_LINES-1:0] tx_clr,
    input  logic [NUM_LINES-1:0] tx_cmpl,
    input  logic [NUM_LINES-1:0] tx_ie,
    input  logic                 csr_wr_en,
    input  logic                 csr_wr_grp,
    input  logic [LW-1:0]        csr_wr_line,
    input  logic                 csr_wr_ie,
    input  logic                 csr_wr_ie_old,
    input  logic                 csr_wr_done,
    input  logic                 rx_ack,
    input  logic                 tx_ack,
    output logic                 rx_irq,
    output logic                 tx_irq,
    output logic [NUM_LINES-1:0] rx_pend,
    output logic [NUM_LINES-1:0] tx_pend,
    output logic [VEC_W-1:0]     rx_vec,
    output logic [VEC_W-1:0]     tx_vec
);
    logic [NUM_GROUPS-1:0][NUM_LINES-1:0] grp_set, grp_clr, grp_pend;
    logic [NUM_GROUPS-1:0][VEC_W-1:0]     grp_vec;
    logic [NUM_GROUPS-1:0]                grp_ack, grp_irq;
    logic [NUM_LINES-1:0] csr_hit, csr_raise, csr_drop;
    grp_e wr_grp;

    assign wr_grp = grp_e'(csr_wr_grp);

    always_comb begin
        for (int i = 0; i < NUM_LINES; i++) begin
            csr_hit[i] = csr_wr_en && (csr_wr_line == LW'(i));
        end
        csr_drop  = csr_hit & {NUM_LINES{~csr_wr_ie}};
        csr_raise = csr_hit & {NUM_LINES{csr_wr_ie & csr_wr_done & ~csr_wr_ie_old}};

        grp_set[GRP_RX] = rx_set;
        grp_clr[GRP_RX] = rx_clr | line_reset;
        grp_set[GRP_TX] = tx_set | (tx_cmpl & tx_ie);
        grp_clr[GRP_TX] = tx_clr | line_reset;

        if (wr_grp == GRP_TX) begin
            grp_set[GRP_TX] = grp_set[GRP_TX] | csr_raise;
            grp_clr[GRP_TX] = grp_clr[GRP_TX] | csr_drop;
        end else begin
            grp_set[GRP_RX] = grp_set[GRP_RX] | csr_raise;
            grp_clr[GRP_RX] = grp_clr[GRP_RX] | csr_drop;
        end

        grp_ack[GRP_RX] = rx_ack;
        grp_ack[GRP_TX] = tx_ack;
    end

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        irq_pend_group #(
            .NUM_LINES   (NUM_LINES),
            .VEC_W       (VEC_W),
            .LINE_STRIDE (LINE_STRIDE),
            .GRP_OFFSET  ((g == int'(GRP_TX)) ? TX_OFFSET : 0)
        ) u_grp (
            .clk      (clk),
            .rst_n    (rst_n),
            .vec_base (vec_base),
            .set_in   (grp_set[g]),
            .clr_in   (grp_clr[g]),
            .ack      (grp_ack[g]),
            .pend     (grp_pend[g]),
            .irq      (grp_irq[g]),
            .vec      (grp_vec[g])
        );
    end

    assign rx_irq  = grp_irq[GRP_RX];
    assign tx_irq  = grp_irq[GRP_TX];
    assign rx_pend = grp_pend[GRP_RX];
    assign tx_pend = grp_pend[GRP_TX];
    assign rx_vec  = grp_vec[GRP_RX];
    assign tx_vec  = grp_vec[GRP_TX];
endmodule

// File: rtl/irq_line_arbiter_chk.sv
module irq_line_arbiter_chk #(
    parameter int NUM_LINES   = 16,
    parameter int VEC_W       = 9,
    parameter int LINE_STRIDE = 8,
    parameter int TX_OFFSET   = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [VEC_W-1:0]     vec_base,
    input logic [NUM_LINES-1:0] line_reset,
    input logic [NUM_LINES-1:0] rx_set,
    input logic [NUM_LINES-1:0] rx_clr,
    input logic [NUM_LINES-1:0] tx_set,
    input logic [NUM_LINES-1:0] tx_cmpl,
    input logic [NUM_LINES-1:0] tx_ie,
    input logic                 csr_wr_en,
    input logic                 rx_ack,
    input logic                 tx_ack,
    input logic                 rx_irq,
    input logic                 tx_irq,
    input logic [NUM_LINES-1:0] rx_pend,
    input logic [NUM_LINES-1:0] tx_pend,
    input logic [VEC_W-1:0]     rx_vec,
    input logic [VEC_W-1:0]     tx_vec
);
    localparam logic [VEC_W-1:0] SLOT_MASK = VEC_W'(LINE_STRIDE - 1);

    assert_rx_master_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq == (rx_pend != '0));
    assert_tx_master_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq == (tx_pend != '0));

    assert_ack_clears_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ack && rx_pend != '0 && rx_set == '0 && rx_clr == '0
         && line_reset == '0 && !csr_wr_en)
        |=> $countones(rx_pend) == $countones($past(rx_pend)) - 1);

    assert_rx_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ack && rx_pend != '0) |=> ((rx_vec - $past(vec_base)) & SLOT_MASK) == '0);
    assert_tx_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ack && tx_pend != '0)
        |=> ((tx_vec - $past(vec_base)) & SLOT_MASK) == VEC_W'(TX_OFFSET));

    assert_empty_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ack && rx_pend == '0 && rx_set == '0 && !csr_wr_en) |=> rx_vec == '0);

    assert_line_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (line_reset != '0 && !csr_wr_en)
        |=> (($past(line_reset & ~rx_set) & rx_pend) == '0));

    assert_rx_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_set != '0) |=> (($past(rx_set) & ~rx_pend) == '0));
    assert_tx_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((tx_set | (tx_cmpl & tx_ie)) != '0)
        |=> (($past(tx_set | (tx_cmpl & tx_ie)) & ~tx_pend) == '0));
endmodule

bind irq_line_arbiter irq_line_arbiter_chk #(
    .NUM_LINES   (NUM_LINES),
    .VEC_W       (VEC_W),
    .LINE_STRIDE (LINE_STRIDE),
    .TX_OFFSET   (TX_OFFSET)
) u_chk (.*);

// File: tb/irq_line_arbiter_test.sv
`timescale 1ns/1ps
module irq_line_arbiter_test;
    localparam int N = 16;
    localparam int VW = 9;

    logic clk = 1'b0;
    logic rst_n;
    logic [VW-1:0] vec_base;
    logic [N-1:0] line_reset, rx_set, rx_clr, tx_set, tx_clr, tx_cmpl, tx_ie;
    logic csr_wr_en, csr_wr_grp, csr_wr_ie, csr_wr_ie_old, csr_wr_done;
    logic [3:0] csr_wr_line;
    logic rx_ack, tx_ack, rx_irq, tx_irq;
    logic [N-1:0] rx_pend, tx_pend;
    logic [VW-1:0] rx_vec, tx_vec;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    irq_line_arbiter uut (
        .clk(clk), .rst_n(rst_n), .vec_base(vec_base), .line_reset(line_reset),
        .rx_set(rx_set), .rx_clr(rx_clr), .tx_set(tx_set), .tx_clr(tx_clr),
        .tx_cmpl(tx_cmpl), .tx_ie(tx_ie), .csr_wr_en(csr_wr_en),
        .csr_wr_grp(csr_wr_grp), .csr_wr_line(csr_wr_line), .csr_wr_ie(csr_wr_ie),
        .csr_wr_ie_old(csr_wr_ie_old), .csr_wr_done(csr_wr_done),
        .rx_ack(rx_ack), .tx_ack(tx_ack), .rx_irq(rx_irq), .tx_irq(tx_irq),
        .rx_pend(rx_pend), .tx_pend(tx_pend), .rx_vec(rx_vec), .tx_vec(tx_vec)
    );

    localparam logic [VW-1:0] BASE = 9'd64;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        line_reset = '0; rx_set = '0; rx_clr = '0; tx_set = '0; tx_clr = '0;
        tx_cmpl = '0; tx_ie = '0; csr_wr_en = 0; csr_wr_grp = 0; csr_wr_line = '0;
        csr_wr_ie = 0; csr_wr_ie_old = 0; csr_wr_done = 0; rx_ack = 0; tx_ack = 0;
    endtask

    // one clock edge passes; returns at the following falling edge
    task automatic cycle();
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic csr_write(logic grp, logic [3:0] ln, logic ie, logic ie_old, logic done);
        csr_wr_en = 1; csr_wr_grp = grp; csr_wr_line = ln;
        csr_wr_ie = ie; csr_wr_ie_old = ie_old; csr_wr_done = done;
        cycle();
    endtask

    task automatic t_reset_state();
        check("R1 rx_irq at reset", 32'(rx_irq), 0);
        check("R1 rx_pend at reset", 32'(rx_pend), 0);
        check("R3 rx_vec at reset", 32'(rx_vec), 0);
        check("R1 tx_irq at reset", 32'(tx_irq), 0);
    endtask

    task automatic t_rx_order();
        rx_set = 16'h0208; cycle();
        check("R10 rx direct set", 32'(rx_pend), 32'h0208);
        check("R1 rx_irq high", 32'(rx_irq), 1);
        rx_ack = 1; cycle();
        check("R2 lowest line 3 served", 32'(rx_pend), 32'h0200);
        check("R3 rx vector line 3", 32'(rx_vec), 88);
        cycle();
        check("R3 vector held without ack", 32'(rx_vec), 88);
        rx_ack = 1; cycle();
        check("R3 rx vector line 9", 32'(rx_vec), 136);
        check("R1 rx_irq low when empty", 32'(rx_irq), 0);
        rx_ack = 1; cycle();
        check("R4 empty ack vector 0", 32'(rx_vec), 0);
        check("R4 empty ack pend unchanged", 32'(rx_pend), 0);
    endtask

    task automatic t_tx_complete();
        tx_cmpl = 16'h8081; tx_ie = 16'h8001; cycle();
        check("R7 tx completion gated by enable", 32'(tx_pend), 32'h8001);
        check("R1 tx_irq high", 32'(tx_irq), 1);
        tx_ack = 1; cycle();
        check("R3 tx vector line 0", 32'(tx_vec), 68);
        tx_ack = 1; cycle();
        check("R3 tx vector line 15", 32'(tx_vec), 188);
        check("R1 tx_irq low", 32'(tx_irq), 0);
    endtask

    task automatic t_csr_rules();
        rx_set = 16'h0010; cycle();
        csr_write(0, 4'd4, 0, 1, 1);
        check("R5 enable clear drops rx line 4", 32'(rx_pend), 0);
        csr_write(1, 4'd6, 1, 0, 1);
        check("R6 enable rise with done raises tx 6", 32'(tx_pend), 32'h0040);
        tx_clr = 16'h0040; cycle();
        check("R10 direct tx clear", 32'(tx_pend), 0);
        csr_write(0, 4'd2, 1, 1, 1);
        check("R6 enable already set no effect", 32'(rx_pend), 0);
        csr_write(0, 4'd2, 1, 0, 0);
        check("R6 done clear no effect", 32'(rx_pend), 0);
        tx_set = 16'h0100; cycle();
        csr_write(1, 4'd8, 0, 1, 0);
        check("R5 enable clear drops tx line 8", 32'(tx_pend), 0);
    endtask

    task automatic t_line_reset();
        rx_set = 16'h0002; tx_set = 16'h0006; cycle();
        line_reset = 16'h0002; cycle();
        check("R8 line reset rx", 32'(rx_pend), 0);
        check("R8 line reset tx", 32'(tx_pend), 32'h0004);
        tx_clr = 16'h0004; rx_clr = 16'h0001; cycle();
        check("R10 tx clear leaves empty", 32'(tx_pend), 0);
    endtask

    task automatic t_set_priority();
        rx_set = 16'h0008; cycle();
        rx_ack = 1; rx_set = 16'h0008; rx_clr = 16'h0008; line_reset = 16'h0008; cycle();
        check("R9 set beats ack/clear/reset", 32'(rx_pend), 32'h0008);
        check("R9 ack still reports line 3", 32'(rx_vec), 88);
        rx_clr = 16'h0008; cycle();
        check("R10 rx clear", 32'(rx_pend), 0);
    endtask

    task automatic t_back_to_back();
        rx_set = 16'h0011; cycle();
        rx_ack = 1;
        @(posedge clk); @(negedge clk);
        check("R10 first of two acks vector", 32'(rx_vec), 64);
        check("R2 first of two acks pend", 32'(rx_pend), 32'h0010);
        rx_ack = 1; cycle();
        check("R3 second ack line 4", 32'(rx_vec), 96);
        check("R2 second ack empties", 32'(rx_pend), 0);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        vec_base = BASE;
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        t_reset_state();
        t_rx_order();
        t_tx_complete();
        t_csr_rules();
        t_line_reset();
        t_set_priority();
        t_back_to_back();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule